// File: doc/BRIEF.md
# Key-Protected Configuration Register Bank

This block is a small bank of configuration registers behind a simple word-wide access port. Software reads any register at any time. It may change a configuration register only after it has opened the bank with an ordered pair of key writes to two dedicated unlock registers. One register also needs a matching key in a companion lock register. Two registers keep their contents against later writes: one as a whole, the other bit by bit.

A write that the bank refuses leaves its target unchanged and raises a one-cycle error strobe. The stored bits have no meaning inside the block. Downstream logic uses them as pin enables, clock selects or access rights.

The unlock state machine has three states. `KS_LOCKED` is the reset state and refuses all configuration writes. `KS_HALF` means the first key has arrived. `KS_OPEN` accepts configuration writes. Its transitions are:
- key-0 write to the first unlock register: `KS_LOCKED` or `KS_HALF` goes to `KS_HALF`, and `KS_OPEN` stays in `KS_OPEN`.
- key-1 write to the second unlock register: `KS_HALF` or `KS_OPEN` goes to `KS_OPEN`, and `KS_LOCKED` stays in `KS_LOCKED`.
- any other value written to either unlock register: every state goes to `KS_LOCKED`.
- writes to any other address leave the state unchanged.

Top module: `cfg_key_bank`

## Requirements
- R1: After reset the unlock state is `KS_LOCKED`. Every register reads 0, except the privilege register at 0x41C, which reads 0xAAAAAAAA.
- R2: Writing 0x83E70B13 to 0x38 and then 0x95A4F1E0 to 0x3C opens the bank. A configuration write issued in the cycle after the second key write is accepted.
- R3: Any value other than its key, written to either unlock register, returns the state to `KS_LOCKED`. The key for 0x3C written while in `KS_LOCKED` also leaves the state in `KS_LOCKED`.
- R4: While the bank is open, a non-key value written to 0x38 relocks it. A configuration write in the very next cycle is refused.
- R5: The guarded register at 0x40008 accepts a write only while the bank is open and the lock register at 0x40004 holds 0x0F0A0B00.
- R6: Writes to the lock register (0x40004), the privilege register (0x41C), the whole-once register (0x40010) and the bit-once register (0x40014) are refused while the bank is not open.
- R7: The whole-once register at 0x40010 stores the first accepted write. Every later write to it is refused until reset.
- R8: In the bit-once register at 0x40014, each bit in the mask 0x0000FFFF freezes at 1 once an accepted write has set it, until reset. The other bits follow every accepted write. Writing to a frozen bit raises no error.
- R9: A refused write, including one to an unmapped address, leaves every register unchanged. It drives `wr_err` high in exactly the cycle after the clock edge that took the write.
- R10: `rdata` shows the addressed register combinationally in the same cycle. The unlock registers, the lock register and unmapped addresses read 0.
- R11: A write to either unlock register never raises `wr_err`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | ADDR_W (20) | Byte address of the access |
| wdata | input | 32 | Write data |
| wen | input | 1 | Write strobe, one write per cycle |
| rdata | output | 32 | Read data for `addr`, combinational |
| wr_err | output | 1 | High for one cycle after a refused write |

## Verification
A write takes effect at the rising edge where `wen` is high. The stored value appears on `rdata` in the following cycle, with no further delay. `wr_err` comes from one register, so it is due in that same following cycle. The bench drives inputs on falling edges. It samples `rdata` and `wr_err` shortly after each falling edge and compares them with a behavioural model that was updated at the preceding rising edge. This way every write result, error strobe and relock is checked in the cycle it is due. Back-to-back writes check the relock timing of R4.

// File: rtl/cfg_key_pkg.sv
package cfg_key_pkg;
    typedef enum logic [1:0] {
        KS_LOCKED = 2'd0,
        KS_HALF   = 2'd1,
        KS_OPEN   = 2'd2
    } kick_state_e;

    localparam int unsigned DATA_W = 32;
endpackage

// File: rtl/cfg_kick_fsm.sv
module cfg_kick_fsm
    import cfg_key_pkg::*;
#(
    parameter int unsigned          ADDR_W = 20,
    parameter logic [ADDR_W-1:0]    K0_ADDR = ADDR_W'('h38),
    parameter logic [ADDR_W-1:0]    K1_ADDR = ADDR_W'('h3C),
    parameter logic [DATA_W-1:0]    KEY0 = 32'h83E7_0B13,
    parameter logic [DATA_W-1:0]    KEY1 = 32'h95A4_F1E0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wen,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              open_o
);
    kick_state_e st_q, st_d;
    logic k0_hit, k1_hit, k0_ok, k1_ok;

    assign k0_hit = wen && (addr == K0_ADDR);
    assign k1_hit = wen && (addr == K1_ADDR);
    assign k0_ok  = (wdata == KEY0);
    assign k1_ok  = (wdata == KEY1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= KS_LOCKED;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            KS_LOCKED: begin
                if (k0_hit)      st_d = k0_ok ? KS_HALF : KS_LOCKED;
                else if (k1_hit) st_d = KS_LOCKED;
            end
            KS_HALF: begin
                if (k0_hit)      st_d = k0_ok ? KS_HALF : KS_LOCKED;
                else if (k1_hit) st_d = k1_ok ? KS_OPEN : KS_LOCKED;
            end
            KS_OPEN: begin
                if (k0_hit)      st_d = k0_ok ? KS_OPEN : KS_LOCKED;
                else if (k1_hit) st_d = k1_ok ? KS_OPEN : KS_LOCKED;
            end
            default: st_d = KS_LOCKED;
        endcase
    end

    always_comb begin
        open_o = (st_q == KS_OPEN);
    end
endmodule

// File: rtl/cfg_key_lock.sv
module cfg_key_lock
    import cfg_key_pkg::*;
#(
    parameter logic [DATA_W-1:0] LOCK_KEY = 32'h0F0A_0B00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic              match
);
    logic [DATA_W-1:0] lock_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  lock_q <= '0;
        else if (we) lock_q <= wdata;
    end

    assign match = (lock_q == LOCK_KEY);
endmodule

// File: rtl/cfg_once_word.sv
module cfg_once_word
    import cfg_key_pkg::*;
#(
    parameter bit                WHOLE = 1'b1,
    parameter logic [DATA_W-1:0] MASK  = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] q,
    output logic              rej
);
    generate
        if (WHOLE) begin : g_whole
            logic done_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    q      <= '0;
                    done_q <= 1'b0;
                end else if (sel && !done_q) begin
                    q      <= wdata;
                    done_q <= 1'b1;
                end
            end
            assign rej = sel && done_q;
        end else begin : g_bits
            logic [DATA_W-1:0] frz_q;
            for (genvar i = 0; i < DATA_W; i++) begin : g_bit
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) begin
                        q[i]     <= 1'b0;
                        frz_q[i] <= 1'b0;
                    end else if (sel && !frz_q[i]) begin
                        q[i]     <= wdata[i];
                        frz_q[i] <= MASK[i] && wdata[i];
                    end
                end
            end
            assign rej = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/cfg_key_bank.sv
module cfg_key_bank
    import cfg_key_pkg::*;
#(
    parameter int unsigned       ADDR_W     = 20,
    parameter logic [ADDR_W-1:0] KICK0_ADDR = ADDR_W'('h00038),
    parameter logic [ADDR_W-1:0] KICK1_ADDR = ADDR_W'('h0003C),
    parameter logic [ADDR_W-1:0] LOCK_ADDR  = ADDR_W'('h40004),
    parameter logic [ADDR_W-1:0] GUARD_ADDR = ADDR_W'('h40008),
    parameter logic [ADDR_W-1:0] ONCE_ADDR  = ADDR_W'('h40010),
    parameter logic [ADDR_W-1:0] BITS_ADDR  = ADDR_W'('h40014),
    parameter logic [ADDR_W-1:0] PRIV_ADDR  = ADDR_W'('h0041C),
    parameter logic [31:0]       KEY0       = 32'h83E7_0B13,
    parameter logic [31:0]       KEY1       = 32'h95A4_F1E0,
    parameter logic [31:0]       LOCK_KEY   = 32'h0F0A_0B00,
    parameter logic [31:0]       PRIV_RST   = 32'hAAAA_AAAA,
    parameter logic [31:0]       BITS_MASK  = 32'h0000_FFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    input  logic              wen,
    output logic [31:0]       rdata,
    output logic              wr_err
);
    logic kick_open, lock_match;
    logic hit_k0, hit_k1, hit_lock, hit_guard, hit_once, hit_bits, hit_priv, hit_any;
    logic once_rej, bits_rej, err_d;
    logic [DATA_W-1:0] guard_q, priv_q, once_q, bits_q;

    assign hit_k0    = wen && (addr == KICK0_ADDR);
    assign hit_k1    = wen && (addr == KICK1_ADDR);
    assign hit_lock  = wen && (addr == LOCK_ADDR);
    assign hit_guard = wen && (addr == GUARD_ADDR);
    assign hit_once  = wen && (addr == ONCE_ADDR);
    assign hit_bits  = wen && (addr == BITS_ADDR);
    assign hit_priv  = wen && (addr == PRIV_ADDR);
    assign hit_any   = hit_k0 | hit_k1 | hit_lock | hit_guard | hit_once | hit_bits | hit_priv;

    cfg_kick_fsm #(
        .ADDR_W(ADDR_W), .K0_ADDR(KICK0_ADDR), .K1_ADDR(KICK1_ADDR),
        .KEY0(KEY0), .KEY1(KEY1)
    ) u_kick (
        .clk(clk), .rst_n(rst_n), .wen(wen), .addr(addr), .wdata(wdata),
        .open_o(kick_open)
    );

    cfg_key_lock #(.LOCK_KEY(LOCK_KEY)) u_lock (
        .clk(clk), .rst_n(rst_n), .we(hit_lock && kick_open), .wdata(wdata),
        .match(lock_match)
    );

    cfg_once_word #(.WHOLE(1'b1), .MASK('1)) u_once (
        .clk(clk), .rst_n(rst_n), .sel(hit_once && kick_open), .wdata(wdata),
        .q(once_q), .rej(once_rej)
    );

    cfg_once_word #(.WHOLE(1'b0), .MASK(BITS_MASK)) u_bits (
        .clk(clk), .rst_n(rst_n), .sel(hit_bits && kick_open), .wdata(wdata),
        .q(bits_q), .rej(bits_rej)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            guard_q <= '0;
            priv_q  <= PRIV_RST;
        end else begin
            if (hit_guard && kick_open && lock_match) guard_q <= wdata;
            if (hit_priv && kick_open)                priv_q  <= wdata;
        end
    end

    always_comb begin
        err_d = 1'b0;
        if (wen && !hit_any)                        err_d = 1'b1;
        if ((hit_lock | hit_priv | hit_once | hit_bits) && !kick_open) err_d = 1'b1;
        if (hit_guard && !(kick_open && lock_match)) err_d = 1'b1;
        if (once_rej | bits_rej)                    err_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wr_err <= 1'b0;
        else        wr_err <= err_d;
    end

    always_comb begin
        rdata = '0;
        if (addr == GUARD_ADDR)     rdata = guard_q;
        else if (addr == ONCE_ADDR) rdata = once_q;
        else if (addr == BITS_ADDR) rdata = bits_q;
        else if (addr == PRIV_ADDR) rdata = priv_q;
    end
endmodule

// File: rtl/cfg_key_bank_chk.sv
module cfg_key_bank_chk #(
    parameter int unsigned       ADDR_W     = 20,
    parameter logic [ADDR_W-1:0] KICK0_ADDR = ADDR_W'('h00038),
    parameter logic [ADDR_W-1:0] KICK1_ADDR = ADDR_W'('h0003C),
    parameter logic [ADDR_W-1:0] LOCK_ADDR  = ADDR_W'('h40004),
    parameter logic [ADDR_W-1:0] GUARD_ADDR = ADDR_W'('h40008),
    parameter logic [ADDR_W-1:0] ONCE_ADDR  = ADDR_W'('h40010),
    parameter logic [31:0]       KEY0       = 32'h83E7_0B13,
    parameter logic [31:0]       KEY1       = 32'h95A4_F1E0
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic [31:0]       wdata,
    input logic              wen,
    input logic [31:0]       rdata,
    input logic              wr_err,
    input logic              kick_open
);
    AST_OPEN_FROM_KEY1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(kick_open) |-> $past(wen && addr == KICK1_ADDR && wdata == KEY1)); // R2

    AST_BAD_KICK_RELOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (wen && ((addr == KICK0_ADDR && wdata != KEY0) || (addr == KICK1_ADDR && wdata != KEY1)))
        |=> !kick_open); // R3

    AST_KICK_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (wen && (addr == KICK0_ADDR || addr == KICK1_ADDR)) |=> !wr_err); // R11

    AST_KEYS_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == KICK0_ADDR || addr == KICK1_ADDR || addr == LOCK_ADDR) |-> rdata == 32'h0); // R10

    AST_ERR_HAS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err |-> $past(wen)); // R9

    AST_GUARD_HELD_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(kick_open) && addr == GUARD_ADDR && $past(addr) == GUARD_ADDR)
        |-> rdata == $past(rdata)); // R5

    AST_ONCE_REFUSED_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_err && addr == ONCE_ADDR && $past(addr) == ONCE_ADDR)
        |-> rdata == $past(rdata)); // R7
endmodule

bind cfg_key_bank cfg_key_bank_chk #(
    .ADDR_W(ADDR_W), .KICK0_ADDR(KICK0_ADDR), .KICK1_ADDR(KICK1_ADDR),
    .LOCK_ADDR(LOCK_ADDR), .GUARD_ADDR(GUARD_ADDR), .ONCE_ADDR(ONCE_ADDR),
    .KEY0(KEY0), .KEY1(KEY1)
) u_chk (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wen(wen),
    .rdata(rdata), .wr_err(wr_err), .kick_open(kick_open)
);

// File: tb/sim_cfg_key_bank.sv
`timescale 1ns/1ps
module sim_cfg_key_bank;
    localparam int AW = 20;
    localparam logic [31:0] K0 = 32'h83E7_0B13, K1 = 32'h95A4_F1E0, LK = 32'h0F0A_0B00;
    localparam logic [AW-1:0] A_K0 = 20'h00038, A_K1 = 20'h0003C, A_LOCK = 20'h40004,
        A_GUARD = 20'h40008, A_ONCE = 20'h40010, A_BITS = 20'h40014, A_PRIV = 20'h0041C;

    logic clk = 1'b0, rst_n = 1'b0, wen = 1'b0, wr_err;
    logic [AW-1:0] addr = '0;
    logic [31:0] wdata = '0, rdata;
    int total = 0, bad = 0;
    bit finished = 0;
    string cur_req = "R1", m_tag = "R1";

    // behavioural model state
    int m_kst;
    logic [31:0] m_lock, m_guard, m_once, m_bits, m_bfrz, m_priv;
    bit m_once_done, m_err;

    always #10 clk = ~clk;

    cfg_key_bank u0 (.clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
                     .wen(wen), .rdata(rdata), .wr_err(wr_err));

    function automatic logic [31:0] m_read(logic [AW-1:0] a);
        case (a)
            A_GUARD: return m_guard;
            A_ONCE:  return m_once;
            A_BITS:  return m_bits;
            A_PRIV:  return m_priv;
            default: return 32'h0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_kst = 0; m_lock = 0; m_guard = 0; m_once = 0; m_bits = 0; m_bfrz = 0;
            m_priv = 32'hAAAA_AAAA; m_once_done = 0; m_err = 0;
        end else begin
            m_err = 0;
            m_tag = cur_req;
            if (wen) begin
                case (addr)
                    A_K0: m_kst = (wdata == K0) ? ((m_kst == 2) ? 2 : 1) : 0;
                    A_K1: m_kst = (wdata == K1 && m_kst != 0) ? 2 : 0;
                    A_LOCK: if (m_kst == 2) m_lock = wdata; else m_err = 1;
                    A_GUARD: if (m_kst == 2 && m_lock == LK) m_guard = wdata; else m_err = 1;
                    A_ONCE: if (m_kst == 2 && !m_once_done) begin
                                m_once = wdata; m_once_done = 1;
                            end else m_err = 1;
                    A_BITS: if (m_kst == 2) begin
                                m_bits = (m_bits & m_bfrz) | (wdata & ~m_bfrz);
                                m_bfrz = m_bfrz | (wdata & 32'h0000_FFFF);
                            end else m_err = 1;
                    A_PRIV: if (m_kst == 2) m_priv = wdata; else m_err = 1;
                    default: m_err = 1;
                endcase
            end
        end
    end

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp, string what);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        #2;
        if (rst_n && !finished) begin
            check(wr_err == m_err, (m_err || wr_err) ? m_tag : "R9", {31'h0, wr_err}, {31'h0, m_err}, "wr_err");
            check(rdata == m_read(addr), cur_req, rdata, m_read(addr), "rdata");
        end
    end

    task automatic do_wr(logic [AW-1:0] a, logic [31:0] d, string req);
        cur_req = req; addr = a; wdata = d; wen = 1'b1;
        @(negedge clk);
        wen = 1'b0;
    endtask

    task automatic expect_rd(logic [AW-1:0] a, logic [31:0] exp, string req);
        cur_req = req; addr = a; wen = 1'b0;
        #3;
        check(rdata == exp, req, rdata, exp, "readback");
        @(negedge clk);
    endtask

    task automatic expect_err(bit exp, string req);
        #3;
        check(wr_err == exp, req, {31'h0, wr_err}, {31'h0, exp}, "error strobe");
    endtask

    initial begin
        #(20 * 100000);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset values
        expect_rd(A_PRIV, 32'hAAAA_AAAA, "R1");
        expect_rd(A_GUARD, 32'h0, "R1");
        expect_rd(A_ONCE, 32'h0, "R1");
        // R6 refused while locked
        do_wr(A_PRIV, 32'h1111_2222, "R6"); expect_err(1, "R6");
        expect_rd(A_PRIV, 32'hAAAA_AAAA, "R6");
        do_wr(A_LOCK, LK, "R6"); expect_err(1, "R6");
        // R3 second key first: stays locked
        do_wr(A_K1, K1, "R3"); expect_err(0, "R11");
        do_wr(A_PRIV, 32'h5, "R3"); expect_err(1, "R3");
        // R3 first key then wrong second
        do_wr(A_K0, K0, "R3");
        do_wr(A_K1, 32'h1234, "R3");
        do_wr(A_PRIV, 32'h6, "R3"); expect_err(1, "R3");
        // R2 proper unlock, then immediate write
        do_wr(A_K0, K0, "R2");
        do_wr(A_K1, K1, "R2");
        do_wr(A_PRIV, 32'h1234_5678, "R2"); expect_err(0, "R2");
        expect_rd(A_PRIV, 32'h1234_5678, "R2");
        // R5 guarded register needs lock key
        do_wr(A_GUARD, 32'hDEAD_0001, "R5"); expect_err(1, "R5");
        expect_rd(A_GUARD, 32'h0, "R5");
        do_wr(A_LOCK, LK, "R5");
        expect_rd(A_LOCK, 32'h0, "R10");
        expect_rd(A_K0, 32'h0, "R10");
        do_wr(A_GUARD, 32'hCAFE_0001, "R5"); expect_err(0, "R5");
        expect_rd(A_GUARD, 32'hCAFE_0001, "R5");
        do_wr(A_LOCK, 32'h0F0A_0B01, "R5");
        do_wr(A_GUARD, 32'h7777_7777, "R5"); expect_err(1, "R5");
        expect_rd(A_GUARD, 32'hCAFE_0001, "R5");
        // R7 whole write-once
        do_wr(A_ONCE, 32'h0000_0011, "R7"); expect_err(0, "R7");
        do_wr(A_ONCE, 32'h0000_0022, "R7"); expect_err(1, "R7");
        expect_rd(A_ONCE, 32'h0000_0011, "R7");
        // R8 bit write-once
        do_wr(A_BITS, 32'h000F_00F0, "R8");
        expect_rd(A_BITS, 32'h000F_00F0, "R8");
        do_wr(A_BITS, 32'h0000_0000, "R8"); expect_err(0, "R8");
        expect_rd(A_BITS, 32'h0000_00F0, "R8");
        do_wr(A_BITS, 32'h0003_0F0F, "R8");
        expect_rd(A_BITS, 32'h0003_0FFF, "R8");
        // R9 unmapped address
        do_wr(20'h00100, 32'hFFFF_FFFF, "R9"); expect_err(1, "R9");
        expect_rd(20'h00100, 32'h0, "R10");
        // R4 relock then back-to-back write refused
        do_wr(A_K0, 32'h0, "R4");
        do_wr(A_PRIV, 32'h9999_9999, "R4"); expect_err(1, "R4");
        expect_rd(A_PRIV, 32'h1234_5678, "R4");
        // R1 reset clears write-once state
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        expect_rd(A_ONCE, 32'h0, "R1");
        expect_rd(A_BITS, 32'h0, "R1");
        do_wr(A_K0, K0, "R2");
        do_wr(A_K1, K1, "R2");
        do_wr(A_ONCE, 32'h0000_0033, "R7"); expect_err(0, "R7");
        expect_rd(A_ONCE, 32'h0000_0033, "R7");
        repeat (2) @(negedge clk);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule